// File: doc/BRIEF.md
# Clock-Synchronous Serial Slave with Ready/Busy Handshake

This block is the slave end of a four-wire programming link that is used while a device boots. The host owns the transfer clock. The block recovers the edges of that clock in its own faster system clock domain, using oversampling, and it never produces a clock of its own. Data arrives on the receive line and is captured on rising clock edges. Response data is pushed out on the transmit line at falling clock edges. Every transfer is one byte, sent least significant bit first.

On the chip side, each complete received byte appears on a parallel bus together with a one-cycle valid strobe. Command logic can stage a byte for the next transfer. It also raises a busy request while an erase or a program operation runs. The ready/busy pin is low only when the link is idle and the command logic is idle too, so the host waits for that pin to go low before it starts another byte. Between bytes the transfer clock idles high.

Top module: `sync_serial_slave`

## Requirements
- R1: While rst_ni is low and directly after reset: sdo_o is 1, rdy_busy_o is 0, rx_valid_o is 0 and rx_data_o is 0.
- R2: Bit k of rx_data_o (k = 0..7) is the level of sdi_i at the (k+1)-th rising edge of sclk_i within a byte, so the first bit received is the LSB.
- R3: rx_valid_o is high for exactly one system clock cycle per byte. It rises at the third system clock edge after the eighth sclk_i rising edge is present at the pin, because of two synchronizer stages and one edge-detect register. rx_data_o changes at the same edge and holds until the next byte.
- R4: The first falling edge of sclk_i after idle starts a byte. rdy_busy_o goes high at the same synchronized edge at which sdo_o is updated for that edge.
- R5: At each falling sclk_i edge of a byte, sdo_o takes bit k of the staged byte, where k is the number of rising edges already seen in that byte (LSB first). sdo_o changes only at such edges or at byte completion, and it always drives both levels.
- R6: rdy_busy_o stays high from byte start until the eighth rising edge has been processed. It is also high in every cycle in which op_busy_i is high. Otherwise it is low.
- R7: A tx_load_i pulse while a byte is in progress is ignored. Neither the current byte nor the next one is affected.
- R8: With no byte staged, sdo_o is 1 for a whole byte. At byte completion sdo_o returns to 1 and the staged byte is consumed.
- R9: The bit position restarts at 0 after every eighth rising edge, so consecutive bytes are framed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than sclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Transfer clock from the host, idles high |
| sdi_i | input | 1 | Serial receive data from the host |
| sdo_o | output | 1 | Serial transmit data, push-pull |
| rdy_busy_o | output | 1 | Low = ready for a new byte, high = busy |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_data_o |
| tx_data_i | input | 8 | Byte to stage for transmission |
| tx_load_i | input | 1 | Stage tx_data_i (honoured only while idle) |
| op_busy_i | input | 1 | Busy request from command logic |

## Verification
The assertions assume that each sclk_i level lasts several system clock cycles. Under that assumption the synchronized clock never produces a rising and a falling edge in adjacent cycles, and the receive strobe cannot repeat before eight rises have been seen. They also assume that sdi_i is stable whenever sclk_i rises. The stimulus holds each half period for four system clock cycles and changes sdi_i only together with a falling edge. It pulses tx_load_i either while the link is idle, or in the middle of a byte when it deliberately tests that the load is ignored.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
  parameter int unsigned       WIDTH   = 2,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= {STAGES{RST_VAL[b]}};
      else         q <= {q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = q[STAGES-1];
  end
endmodule

// File: rtl/sss_edge.sv
module sss_edge
  import sss_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  output sclk_edge_t edge_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;  // clock idles high
    else         prev_q <= sig_i;
  end
  assign edge_o.rise = sig_i & ~prev_q;
  assign edge_o.fall = ~sig_i & prev_q;
endmodule

// File: rtl/sss_rx.sv
module sss_rx
  import sss_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sclk_edge_t        edge_i,
  input  logic              sdi_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam logic [CNT_W-1:0] LastBit = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] shift_d;

  assign shift_d = {sdi_i, shift_q[DATA_W-1:1]};
  assign done_o  = edge_i.rise && (bit_cnt_o == LastBit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q    <= '0;
      bit_cnt_o  <= '0;
      active_o   <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (edge_i.fall) active_o <= 1'b1;
      if (edge_i.rise) begin
        shift_q <= shift_d;
        if (done_o) begin
          bit_cnt_o  <= '0;
          active_o   <= 1'b0;
          rx_data_o  <= shift_d;
          rx_valid_o <= 1'b1;
        end else begin
          bit_cnt_o <= bit_cnt_o + 1'b1;
        end
      end
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_cnt_moves_on_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i.rise |=> $stable(bit_cnt_o));
endmodule

// File: rtl/sss_tx.sv
module sss_tx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              done_i,
  input  logic              active_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] buf_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      pend_q <= 1'b0;
      sdo_o  <= 1'b1;
    end else begin
      if (fall_i) sdo_o <= pend_q ? buf_q[bit_cnt_i] : 1'b1;
      if (done_i) begin
        pend_q <= 1'b0;
        sdo_o  <= 1'b1;
      end else if (tx_load_i && !active_i) begin
        buf_q  <= tx_data_i;
        pend_q <= 1'b1;
      end
    end
  end

  assert_load_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_i && active_i) |=> $stable(buf_q));
  assert_idle_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> sdo_o);
  assert_sdo_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !done_i) |=> $stable(sdo_o));
endmodule

// File: rtl/sync_serial_slave.sv
module sync_serial_slave
  import sss_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              rdy_busy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  input  logic              op_busy_i
);
  logic             sclk_s, sdi_s;
  sclk_edge_t       sclk_edge;
  logic [CNT_W-1:0] bit_cnt;
  logic             active, done;

  sss_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({sclk_i, sdi_i}),
    .sync_o ({sclk_s, sdi_s})
  );

  sss_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sclk_s),
    .edge_o(sclk_edge)
  );

  sss_rx #(.DATA_W(DATA_W)) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (sclk_edge),
    .sdi_i     (sdi_s),
    .bit_cnt_o (bit_cnt),
    .active_o  (active),
    .done_o    (done),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o)
  );

  sss_tx #(.DATA_W(DATA_W)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (sclk_edge.fall),
    .done_i   (done),
    .active_i (active),
    .bit_cnt_i(bit_cnt),
    .tx_data_i(tx_data_i),
    .tx_load_i(tx_load_i),
    .sdo_o    (sdo_o)
  );

  assign rdy_busy_o = active | op_busy_i;

  assert_busy_before_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rdy_busy_o));
  assert_busy_at_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_edge.fall |=> rdy_busy_o);
endmodule

// File: tb/test_sync_serial_slave.sv
module test_sync_serial_slave;
  localparam int H = 4;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdi = 1'b1, tx_load = 1'b0, op_busy = 1'b0;
  logic [7:0] tx_data = '0;
  logic sdo, rdy_busy, rx_valid;
  logic [7:0] rx_data;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_serial_slave i_sync_serial_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo),
    .rdy_busy_o(rdy_busy), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .tx_data_i(tx_data), .tx_load_i(tx_load), .op_busy_i(op_busy)
  );

  // reference model: pipeline of pin samples plus byte state
  bit m_c[3], m_d[2];
  int m_cnt;
  bit m_act, m_valid, m_sdo, m_pend;
  logic [7:0] m_shift, m_data, m_buf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c = '{1, 1, 1}; m_d = '{1, 1};
      m_cnt = 0; m_act = 0; m_valid = 0; m_sdo = 1; m_pend = 0;
      m_shift = 0; m_data = 0; m_buf = 0;
    end else begin
      automatic bit rise = m_c[1] && !m_c[2];
      automatic bit fall = !m_c[1] && m_c[2];
      automatic bit was_act = m_act;
      automatic bit fin = 0;
      m_valid = 0;
      if (fall) begin
        m_act = 1;
        m_sdo = m_pend ? m_buf[m_cnt] : 1'b1;
      end
      if (rise) begin
        m_shift = {m_d[1], m_shift[7:1]};
        if (m_cnt == 7) begin
          m_data = m_shift; m_valid = 1; m_cnt = 0; m_act = 0;
          m_pend = 0; m_sdo = 1; fin = 1;
        end else m_cnt++;
      end
      if (!fin && tx_load && !was_act) begin m_buf = tx_data; m_pend = 1; end
      m_c[2] = m_c[1]; m_c[1] = m_c[0]; m_c[0] = sclk;
      m_d[1] = m_d[0]; m_d[0] = sdi;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R3 rx_valid", {7'b0, rx_valid}, {7'b0, m_valid});
      check("R2 rx_data", rx_data, m_data);
      check("R5 R8 sdo", {7'b0, sdo}, {7'b0, m_sdo});
      check("R4 R6 rdy_busy", {7'b0, rdy_busy}, {7'b0, m_act | op_busy});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG);
      finish_run();
    end
  end

  task automatic load(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_load = 1;
    @(negedge clk); tx_load = 0;
  endtask

  task automatic host_byte(input logic [7:0] snd, input logic [7:0] exp_tx,
                           input bit mid_load, input string req);
    logic [7:0] got;
    for (int i = 0; i < 8; i++) begin
      sclk = 0; sdi = snd[i];
      if (mid_load && i == 3) begin tx_data = 8'h99; tx_load = 1; end
      @(negedge clk); tx_load = 0;
      repeat (H - 1) @(negedge clk);
      got[i] = sdo;
      sclk = 1;
      repeat (H) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    check({req, " R2 host rx"}, rx_data, snd);
    check({req, " R5 host tx"}, got, exp_tx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sdo", {7'b0, sdo}, 8'h01);
    check("R1 rdy_busy", {7'b0, rdy_busy}, 8'h00);
    check("R1 rx_valid", {7'b0, rx_valid}, 8'h00);
    check("R1 rx_data", rx_data, 8'h00);
    rst_n = 1;
    repeat (5) @(negedge clk);
    host_byte(8'hA5, 8'hFF, 0, "R8 unloaded");
    load(8'h3C);
    host_byte(8'h5A, 8'h3C, 0, "R5 loaded");
    op_busy = 1;
    load(8'hC3);
    host_byte(8'h00, 8'hC3, 0, "R6 op busy");
    repeat (10) @(negedge clk);
    op_busy = 0;
    repeat (5) @(negedge clk);
    load(8'h81);
    host_byte(8'hFF, 8'h81, 1, "R7 mid load");
    host_byte(8'h7E, 8'hFF, 0, "R7 R8 after ignored load");
    load(8'h12);
    host_byte(8'h34, 8'h12, 0, "R9 first");
    load(8'h56);
    host_byte(8'h78, 8'h56, 0, "R9 second");
    host_byte(8'h01, 8'hFF, 0, "R9 third");
    @(negedge clk); op_busy = 1;
    repeat (3) @(negedge clk); op_busy = 0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule